// File: doc/BRIEF.md
# Head-per-track disk controller

This block sits on a minicomputer I/O bus and moves whole sectors between a fixed-head disk store and host memory. Software loads a sector address and a memory address through register operations, then fires a start-read or start-write control pulse. The controller checks the target disk against its write-lock switch and the attached capacity. If either check fails, it ends the command at once with an encoded error status. Otherwise it goes busy and waits for a separate rotational latency unit to strobe that the target sector is under the heads.

A transfer moves 256 words, one word at a time, over two valid/ready ports. A read fetches each word from the disk port and stores it to the memory port. A write fetches each word from memory and stores it to disk. At the end of a transfer the controller raises done, which drives an interrupt request unless the interrupt-disable mask is set. The memory address register then points past the sector: 256 words on after a read and 259 words on after a write.

A clear pulse, or any other pulse, resets the flags and abandons a transfer in progress. Two status bits, data late and parity, are not produced by the controller itself; test inputs set them.

Top module: `hpt_disk_ctrl`

## Requirements
- R1: After reset, busy, done and irq are 0, the status read returns 0 and the memory address read returns 0.
- R2: Register select codes are 0 read status, 1 load disk address, 2 read memory address, 3 load memory address. A disk address load keeps bits 12:0 of the data. A memory address load keeps the AW (default 15) bits, and the read returns them zero-extended.
- R3: Any control pulse clears busy, done, irq and status, and abandons a transfer in progress: no further port handshakes follow.
- R4: The disk number is bits 12:10 of the disk address, and it selects one bit of the write-lock input. A write pulse to a locked disk sets done, sets status to 0x11 (bit 4 locked, bit 0 summary) and starts no transfer. A read pulse ignores the lock.
- R5: A read or write whose disk address times 256 is at or above the capacity input sets done, sets status to 0x05 (bit 2 nonexistent, bit 0 summary) and starts no transfer.
- R6: A valid read or write raises busy. No memory or disk handshake occurs until the sector-arrival strobe is seen.
- R7: A read copies disk word (address*256 + i) to memory word (memory address + i) for i = 0..255, in order, then adds 256 to the memory address.
- R8: A write copies memory word (memory address + i) to disk word (address*256 + i) for i = 0..255, in order, then adds 259 to the memory address.
- R9: At the end of a transfer busy clears, done sets and status clears. The irq output equals done AND NOT the mask input.
- R10: Memory addresses, both per word and after the advance, wrap modulo 2^AW.
- R11: The data-late test input ORs 0x09 into status, and the parity test input ORs 0x03.
- R12: When read and write pulses arrive together, the command is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register load strobe |
| reg_sel | input | 2 | Register operation select |
| reg_wdata | input | AW | Load data |
| reg_rdata | output | DW | Read data for the selected register |
| pls_clr | input | 1 | Clear pulse |
| pls_rd | input | 1 | Start-read pulse |
| pls_wr | input | 1 | Start-write pulse |
| irq_mask | input | 1 | Interrupt disable for this device |
| wlock | input | 8 | Per-disk write-lock switches |
| cap_words | input | 22 | Attached capacity in words |
| sector_here | input | 1 | Target sector arrival strobe |
| tst_late | input | 1 | Test: inject data-late error |
| tst_parity | input | 1 | Test: inject parity error |
| target_da | output | 13 | Current disk address, for the latency unit |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished |
| irq | output | 1 | Interrupt request |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts request |
| mem_rdata | input | DW | Memory read data, valid with ready |
| dsk_valid | output | 1 | Disk request valid |
| dsk_we | output | 1 | Disk request is a write |
| dsk_addr | output | 21 | Disk word address |
| dsk_wdata | output | DW | Disk write data |
| dsk_ready | input | 1 | Disk accepts request |
| dsk_rdata | input | DW | Disk read data, valid with ready |

## Verification
The embedded properties check these rules on every cycle:
- the immediate error outcomes of a locked write and of an out-of-range address;
- the effect of a bare clear pulse;
- that busy and done are never both set;
- that a fresh command issues no handshake;
- the exact memory-address advance after a read or a write.

Only the bench's scenarios can show the rest:
- the full ordered word stream with correct data under stalling ready patterns;
- address wrap inside a sector;
- that an aborted transfer stays silent even after a later arrival strobe;
- that masking applies to the disk number derived from a freshly loaded address.

// File: rtl/hpt_disk_ctrl.sv
module hpt_disk_ctrl #(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter int WPS = 256,
  parameter int SEC_PER_TRK = 8,
  parameter int TRK_PER_DISK = 128,
  parameter int DISKS = 8,
  localparam int WIX_W = $clog2(WPS),
  localparam int DK_W = $clog2(DISKS),
  localparam int DA_W = DK_W + $clog2(SEC_PER_TRK * TRK_PER_DISK),
  localparam int XA_W = DA_W + WIX_W,
  localparam int CAP_W = XA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [AW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             pls_clr,
  input  logic             pls_rd,
  input  logic             pls_wr,
  input  logic             irq_mask,
  input  logic [DISKS-1:0] wlock,
  input  logic [CAP_W-1:0] cap_words,
  input  logic             sector_here,
  input  logic             tst_late,
  input  logic             tst_parity,
  output logic [DA_W-1:0]  target_da,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             mem_valid,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_rdata,
  output logic             dsk_valid,
  output logic             dsk_we,
  output logic [XA_W-1:0]  dsk_addr,
  output logic [DW-1:0]    dsk_wdata,
  input  logic             dsk_ready,
  input  logic [DW-1:0]    dsk_rdata
);
  localparam logic [4:0] ST_LOCK = 5'h11;
  localparam logic [4:0] ST_NODISK = 5'h05;
  localparam logic [AW-1:0] ADV_RD = AW'(WPS);
  localparam logic [AW-1:0] ADV_WR = AW'(WPS + 3);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GET, S_PUT} st_t;

  st_t              st;
  logic             fn_wr;
  logic [DA_W-1:0]  da;
  logic [AW-1:0]    ma;
  logic [4:0]       stat, stat_n;
  logic             busy_q, done_q;
  logic [WIX_W-1:0] wix;
  logic [DW-1:0]    wbuf;

  wire any_pls = pls_clr | pls_rd | pls_wr;
  wire ld_da = reg_wr && reg_sel == 2'd1;
  wire ld_ma = reg_wr && reg_sel == 2'd3;
  wire [DA_W-1:0] da_n = ld_da ? reg_wdata[DA_W-1:0] : da;
  wire [DK_W-1:0] dk_n = da_n[DA_W-1 -: DK_W];
  wire locked = pls_wr && wlock[dk_n];
  wire no_disk = (pls_rd || pls_wr) && !locked &&
                 ({1'b0, da_n, {WIX_W{1'b0}}} >= cap_words);
  wire go = (pls_rd || pls_wr) && !locked && !no_disk;
  wire step = (mem_valid && mem_ready) || (dsk_valid && dsk_ready);
  wire last = st == S_PUT && step && (&wix);

  assign dsk_valid = (st == S_GET && !fn_wr) || (st == S_PUT && fn_wr);
  assign mem_valid = (st == S_GET && fn_wr) || (st == S_PUT && !fn_wr);
  assign mem_we = !fn_wr;
  assign dsk_we = fn_wr;
  assign mem_addr = ma + AW'(wix);
  assign dsk_addr = {da, wix};
  assign mem_wdata = wbuf;
  assign dsk_wdata = wbuf;
  assign target_da = da;
  assign busy = busy_q;
  assign done = done_q;
  assign irq = done_q & ~irq_mask;

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = DW'(stat);
      2'd2:    reg_rdata = DW'(ma);
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    stat_n = stat;
    if (any_pls) stat_n = locked ? ST_LOCK : (no_disk ? ST_NODISK : 5'h00);
    else if (last) stat_n = 5'h00;
    if (tst_late) stat_n = stat_n | 5'h09;
    if (tst_parity) stat_n = stat_n | 5'h03;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      fn_wr <= 1'b0;
      da <= '0;
      ma <= '0;
      stat <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wix <= '0;
      wbuf <= '0;
    end else begin
      stat <= stat_n;
      da <= da_n;
      if (ld_ma) ma <= reg_wdata;
      else if (last && !any_pls) ma <= ma + (fn_wr ? ADV_WR : ADV_RD);
      if (any_pls) begin
        busy_q <= go;
        done_q <= locked | no_disk;
        st <= go ? S_WAIT : S_IDLE;
        fn_wr <= pls_wr;
        wix <= '0;
      end else begin
        case (st)
          S_WAIT: if (sector_here) st <= S_GET;
          S_GET: if (step) begin
            wbuf <= fn_wr ? mem_rdata : dsk_rdata;
            st <= S_PUT;
          end
          S_PUT: if (step) begin
            wix <= wix + 1'b1;
            if (last) begin
              st <= S_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else st <= S_GET;
          end
          default: ;
        endcase
      end
    end
  end

  a_r9_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  a_r6_no_early_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !mem_valid && !dsk_valid);

  a_r4_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    pls_wr && wlock[dk_n] && !tst_late && !tst_parity
    |=> done_q && !busy_q && stat == ST_LOCK && !mem_valid && !dsk_valid);

  a_r5_beyond_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    (pls_rd || pls_wr) && !(pls_wr && wlock[dk_n]) && !tst_late && !tst_parity &&
    ({1'b0, da_n, {WIX_W{1'b0}}} >= cap_words)
    |=> done_q && !busy_q && stat == ST_NODISK);

  a_r3_clear_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pls_clr && !pls_rd && !pls_wr && !tst_late && !tst_parity
    |=> !busy_q && !done_q && stat == 5'h00 && !mem_valid && !dsk_valid);

  a_r7_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    last && !fn_wr && !any_pls && !ld_ma |=> ma == $past(ma) + ADV_RD);

  a_r8_write_advance: assert property (@(posedge clk) disable iff (!rst_n)
    last && fn_wr && !any_pls && !ld_ma |=> ma == $past(ma) + ADV_WR);
endmodule

// File: tb/hpt_disk_ctrl_tb_top.sv
`timescale 1ns/1ps
module hpt_disk_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [14:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic pls_clr = 1'b0, pls_rd = 1'b0, pls_wr = 1'b0;
  logic irq_mask = 1'b0;
  logic [7:0] wlock = 8'h00;
  logic [21:0] cap_words = 22'h200000;
  logic sector_here = 1'b0, tst_late = 1'b0, tst_parity = 1'b0;
  logic [12:0] target_da;
  logic busy, done, irq;
  logic mem_valid, mem_we, dsk_valid, dsk_we;
  logic [14:0] mem_addr;
  logic [20:0] dsk_addr;
  logic [15:0] mem_wdata, dsk_wdata, mem_rdata, dsk_rdata;
  logic mem_ready = 1'b1, dsk_ready = 1'b1;

  always #2.5 clk = ~clk;

  hpt_disk_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pls_clr(pls_clr),
    .pls_rd(pls_rd), .pls_wr(pls_wr), .irq_mask(irq_mask), .wlock(wlock),
    .cap_words(cap_words), .sector_here(sector_here), .tst_late(tst_late),
    .tst_parity(tst_parity), .target_da(target_da), .busy(busy), .done(done),
    .irq(irq), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .dsk_valid(dsk_valid), .dsk_we(dsk_we), .dsk_addr(dsk_addr),
    .dsk_wdata(dsk_wdata), .dsk_ready(dsk_ready), .dsk_rdata(dsk_rdata));

  function automatic logic [15:0] mem_pat(input logic [14:0] a);
    return 16'(a * 16'h9E37) ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] dsk_pat(input logic [20:0] a);
    return 16'(a[15:0] * 16'h02B1) ^ {11'b0, a[20:16]} ^ 16'hC3C3;
  endfunction
  assign mem_rdata = mem_pat(mem_addr);
  assign dsk_rdata = dsk_pat(dsk_addr);

  typedef struct packed {
    logic is_mem; logic we; logic [20:0] addr; logic [15:0] data;
  } item_t;
  item_t exp_q[$];
  int errs = 0, checks = 0, hs_cnt = 0, rdy_ctr = 0;
  bit slow = 1'b0;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic observe(input logic is_mem, input logic we, input logic [20:0] addr,
                         input logic [15:0] data);
    item_t e;
    hs_cnt++;
    checks++;
    if (exp_q.size() == 0) begin
      errs++;
      $display("FAIL R3/R6 unexpected handshake: actual=%b/%h expected=none", is_mem, addr);
      return;
    end
    e = exp_q.pop_front();
    if (e.is_mem !== is_mem || e.we !== we || e.addr !== addr || (we && e.data !== data)) begin
      errs++;
      $display("FAIL R7/R8/R10 transfer: actual=%b%b %h %h expected=%b%b %h %h",
               is_mem, we, addr, data, e.is_mem, e.we, e.addr, e.data);
    end
  endtask

  always @(negedge clk) begin
    rdy_ctr++;
    mem_ready = slow ? (rdy_ctr % 3 != 0) : 1'b1;
    dsk_ready = slow ? (rdy_ctr % 4 != 1) : 1'b1;
    if (mem_valid && mem_ready) observe(1'b1, mem_we, 21'(mem_addr), mem_wdata);
    if (dsk_valid && dsk_ready) observe(1'b0, dsk_we, dsk_addr, dsk_wdata);
  end

  task automatic reg_load(input logic [1:0] sel, input logic [14:0] val);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); reg_wr = 1'b0; reg_sel = 2'd0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [15:0] v);
    reg_sel = sel; #1 v = reg_rdata; reg_sel = 2'd0;
  endtask

  task automatic pulse(input bit c, input bit r, input bit w);
    @(negedge clk); pls_clr = c; pls_rd = r; pls_wr = w;
    @(negedge clk); pls_clr = 1'b0; pls_rd = 1'b0; pls_wr = 1'b0;
  endtask

  task automatic arrive();
    @(negedge clk); sector_here = 1'b1;
    @(negedge clk); sector_here = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(tag, 32'(done), 32'd1);
  endtask

  task automatic push_read(input logic [12:0] da, input logic [14:0] ma);
    for (int i = 0; i < 256; i++) begin
      logic [20:0] d = {da, 8'(i)};
      exp_q.push_back('{1'b0, 1'b0, d, 16'h0});
      exp_q.push_back('{1'b1, 1'b1, 21'(15'(ma + 15'(i))), dsk_pat(d)});
    end
  endtask

  task automatic push_write(input logic [12:0] da, input logic [14:0] ma);
    for (int i = 0; i < 256; i++) begin
      logic [14:0] m = 15'(ma + 15'(i));
      exp_q.push_back('{1'b1, 1'b0, 21'(m), 16'h0});
      exp_q.push_back('{1'b0, 1'b1, {da, 8'(i)}, mem_pat(m)});
    end
  endtask

  initial begin
    #750000;
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 irq", 32'(irq), 0);
    rd_reg(2'd0, v); chk("R1 status", 32'(v), 0);
    rd_reg(2'd2, v); chk("R1 memaddr", 32'(v), 0);

    // R2 memory address width
    reg_load(2'd3, 15'h7FFF);
    rd_reg(2'd2, v); chk("R2 memaddr readback", 32'(v), 32'h7FFF);

    // R2/R6/R7/R9 read, disk address masked to 13 bits
    reg_load(2'd1, 15'h6005);
    chk("R2 disk addr mask", 32'(target_da), 32'h0005);
    reg_load(2'd3, 15'h0100);
    push_read(13'h0005, 15'h0100);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R6 busy after start", 32'(busy), 1);
    h = hs_cnt;
    repeat (10) @(negedge clk);
    chk("R6 no handshake before arrival", 32'(hs_cnt), 32'(h));
    arrive();
    wait_done("R9 read done");
    @(negedge clk);
    chk("R7 all words moved", 32'(exp_q.size()), 0);
    chk("R9 busy cleared", 32'(busy), 0);
    chk("R9 irq unmasked", 32'(irq), 1);
    rd_reg(2'd0, v); chk("R9 status clear", 32'(v), 0);
    rd_reg(2'd2, v); chk("R7 memaddr +256", 32'(v), 32'h0200);
    irq_mask = 1'b1; #1;
    chk("R9 irq masked", 32'(irq), 0);
    irq_mask = 1'b0;

    // R8/R10 write with wrap, stalling ports
    slow = 1'b1;
    reg_load(2'd1, 15'h0403);
    reg_load(2'd3, 15'h7F80);
    push_write(13'h0403, 15'h7F80);
    pulse(1'b0, 1'b0, 1'b1);
    arrive();
    wait_done("R8 write done");
    @(negedge clk);
    chk("R8 all words moved", 32'(exp_q.size()), 0);
    rd_reg(2'd2, v); chk("R10 memaddr +259 wrapped", 32'(v), 32'h0083);

    // R4 write lock on disk 1 (address 0x0403)
    wlock = 8'h02;
    h = hs_cnt;
    pulse(1'b0, 1'b0, 1'b1);
    chk("R4 done", 32'(done), 1);
    chk("R4 busy", 32'(busy), 0);
    rd_reg(2'd0, v); chk("R4 status", 32'(v), 32'h11);
    arrive();
    repeat (5) @(negedge clk);
    chk("R4 no transfer", 32'(hs_cnt), 32'(h));
    // R12 read+write together is a write
    pulse(1'b0, 1'b1, 1'b1);
    rd_reg(2'd0, v); chk("R12 write wins", 32'(v), 32'h11);
    // R4 read ignores lock, then R3 clear
    pulse(1'b0, 1'b1, 1'b0);
    chk("R4 read ignores lock", 32'(busy), 1);
    chk("R3 prior done cleared", 32'(done), 0);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R3 busy cleared", 32'(busy), 0);
    wlock = 8'h00;

    // R3 abort mid-transfer
    reg_load(2'd1, 15'h0007);
    reg_load(2'd3, 15'h0040);
    push_read(13'h0007, 15'h0040);
    pulse(1'b0, 1'b1, 1'b0);
    arrive();
    repeat (40) @(negedge clk);
    pulse(1'b1, 1'b0, 1'b0);
    exp_q.delete();
    h = hs_cnt;
    arrive();
    repeat (30) @(negedge clk);
    chk("R3 abort silent", 32'(hs_cnt), 32'(h));
    chk("R3 abort busy", 32'(busy), 0);
    chk("R3 abort done", 32'(done), 0);
    rd_reg(2'd0, v); chk("R3 abort status", 32'(v), 0);

    // R5 capacity: 1024 sectors attached
    cap_words = 22'h040000;
    reg_load(2'd1, 15'h0400);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R5 done", 32'(done), 1);
    chk("R5 busy", 32'(busy), 0);
    rd_reg(2'd0, v); chk("R5 status", 32'(v), 32'h05);
    reg_load(2'd1, 15'h03FF);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R5 last sector in range", 32'(busy), 1);
    pulse(1'b1, 1'b0, 1'b0);
    cap_words = 22'h200000;

    // R11 injected errors
    @(negedge clk); tst_late = 1'b1;
    @(negedge clk); tst_late = 1'b0;
    rd_reg(2'd0, v); chk("R11 late", 32'(v), 32'h09);
    pulse(1'b1, 1'b0, 1'b0);
    @(negedge clk); tst_parity = 1'b1;
    @(negedge clk); tst_parity = 1'b0;
    rd_reg(2'd0, v); chk("R11 parity", 32'(v), 32'h03);

    slow = 1'b0;
    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule